// File: doc/BRIEF.md
# Call/Return Stack Frame Engine

This block sequences branches, calls and returns for a small processor core. It owns the program counter, the execution-mode bit and the Z and C flags. It also keeps four hardware return stacks. Stacks A and B sit in a shared memory that is reached through an arbiter grant. Stacks X and Y sit in a private auxiliary memory that answers at once. Each stack has its own pointer.

A call saves a single 32-bit frame at the selected pointer and then moves the pointer up by one. The frame holds the return address, the caller's mode and both flags. A return moves the pointer down by one first and then reads the frame back. A return always restores the mode. It restores each flag only when the instruction asks for it. Branch targets may be absolute or relative to the branch's own address. A branch may flip the mode when it is taken, and a branch may be delayed. A delayed branch lets the next three instructions run before the program counter changes.

The core presents one instruction per cycle when `busy` is low. It must wait while `busy` is high. An instruction presented while `busy` is high is dropped.

Top module: `ccs_engine`

## Requirements
- R1: After a synchronous reset, `pc` is 0, `exec_mode` is 0, both flags are 0 and `busy` is 0.
- R2: Opcode 0 (plain) and opcodes 5 to 7 each advance `pc` by one. Opcode 1 (flag load) also copies `z_in` and `c_in` into Z and C.
- R3: Opcode 2 (jump) moves `pc` to `tgt_val` when `tgt_rel` is 0. When `tgt_rel` is 1, it moves `pc` to the branch's own address plus `tgt_val`, modulo 2^16.
- R4: When `tgl_mode` is 1, a jump or call inverts `exec_mode` as it takes effect. A return ignores `tgl_mode`.
- R5: Opcode 3 (call) writes a frame at the selected pointer and then increments that pointer. The frame has the mode in bit 18, Z in bit 17, C in bit 16 and the return address in bits 15..0. The return address is the call's address plus 1, or plus 4 for a delayed call.
- R6: Opcode 4 (return) decrements the selected pointer first and reads the frame there. It then loads `pc` from bits 15..0 and always loads `exec_mode` from bit 18.
- R7: A return loads Z from bit 17 only when `wr_z` is 1, and loads C from bit 16 only when `wr_c` is 1. A flag that is not enabled keeps its value.
- R8: `stk_sel` picks the stack: 0 is A, 1 is B, 2 is X and 3 is Y. Each stack returns its own frames in last-in, first-out order, whatever the other stacks do.
- R9: A call or return on stack A or B raises `busy` and holds `pc` until `sh_gnt` is seen. An aux call finishes in one cycle without `busy`. An aux return holds `busy` for one cycle. An instruction presented while `busy` is high has no effect.
- R10: With `dly_br` set, a jump, call or return advances `pc` by one. The next three retiring instructions each advance `pc` by one, except that the third one loads the branch's outcome (target, mode and any restored flags) instead.
- R11: A jump, call or return presented while a delayed branch is pending acts as a plain instruction. It pushes nothing, pops nothing and only advances `pc`.
- R12: Pointers wrap modulo their memory depth: 16 words shared, 8 words auxiliary. A and X start at 0, B starts at 8 and Y starts at 4. A ninth push on Y therefore overwrites the oldest frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_op | input | 3 | Opcode (0 plain, 1 flag load, 2 jump, 3 call, 4 return) |
| stk_sel | input | 2 | Stack select (0 A, 1 B, 2 X, 3 Y) |
| tgt_val | input | 16 | Absolute target or relative offset |
| tgt_rel | input | 1 | Target is relative to the branch address |
| tgl_mode | input | 1 | Invert mode when the jump or call is taken |
| dly_br | input | 1 | Delayed branch form |
| wr_z | input | 1 | Return restores Z |
| wr_c | input | 1 | Return restores C |
| z_in | input | 1 | Z value for the flag-load opcode |
| c_in | input | 1 | C value for the flag-load opcode |
| sh_gnt | input | 1 | Grant for the shared memory |
| pc | output | 16 | Program counter |
| exec_mode | output | 1 | Execution mode |
| flag_z | output | 1 | Z flag |
| flag_c | output | 1 | C flag |
| busy | output | 1 | Engine stalled; instructions are dropped |

## Verification
The assertions check on every cycle the properties that hold locally. These are the PC stall and the held wait state while the shared grant is low, and the step or jump of `pc` after a single accepted plain, jump or aux-call instruction. They also check the mode inversion on a toggling jump, the first slot of a delayed jump, and that Z is left alone by a return that does not enable it. Other behaviour spans many instructions, and only the bench scenarios show it:
- the frame layout surviving a round trip through each memory;
- the independence of the four stacks;
- the third-slot hand-over of a delayed call or return;
- the dropping of branches inside a delay window;
- the overwrite caused by pointer wrap.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int PC_W     = 16;
  localparam int WORD_W   = 32;
  localparam int MODE_BIT = 18;
  localparam int ZF_BIT   = 17;
  localparam int CF_BIT   = 16;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SETF = 3'd1,
    OP_JMP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_GNT, ST_RD} st_e;

  typedef struct packed {
    op_e             op;
    logic [1:0]      sel;
    logic [PC_W-1:0] tgt;
    logic            rel;
    logic            tgl;
    logic            dly;
    logic            wz;
    logic            wc;
  } instr_t;

  function automatic logic [WORD_W-1:0] pack_frame(input logic m, input logic z,
                                                   input logic c, input logic [PC_W-1:0] ra);
    logic [WORD_W-1:0] w;
    w = '0;
    w[MODE_BIT] = m;
    w[ZF_BIT]   = z;
    w[CF_BIT]   = c;
    w[PC_W-1:0] = ra;
    return w;
  endfunction
endpackage

// File: rtl/ccs_stack_mem.sv
module ccs_stack_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ccs_ptr_file.sv
module ccs_ptr_file #(
  parameter int SH_DEPTH  = 16,
  parameter int AUX_DEPTH = 8,
  parameter int PW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sel,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] cur,
  output logic [PW-1:0] prev
);
  logic [PW-1:0] ptr [4];
  logic [PW-1:0] bck [4];

  for (genvar i = 0; i < 4; i++) begin : g_ptr
    localparam int            DEP  = (i < 2) ? SH_DEPTH : AUX_DEPTH;
    localparam logic [PW-1:0] MASK = PW'(DEP - 1);
    localparam logic [PW-1:0] BASE = PW'((i % 2) * (DEP / 2));
    logic [PW-1:0] p;
    logic [PW-1:0] up;
    logic [PW-1:0] dn;
    assign up     = (p + PW'(1)) & MASK;
    assign dn     = (p - PW'(1)) & MASK;
    assign ptr[i] = p;
    assign bck[i] = dn;
    always_ff @(posedge clk) begin
      if (rst)                        p <= BASE;
      else if (sel == 2'(i) && inc)   p <= up;
      else if (sel == 2'(i) && dec)   p <= dn;
    end
  end

  assign cur  = ptr[sel];
  assign prev = bck[sel];
endmodule

// File: rtl/ccs_delay.sv
module ccs_delay #(
  parameter int SLOTS = 3,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic retire,
  output logic pending,
  output logic fire
);
  logic [CW-1:0] cnt;

  assign pending = (cnt != '0);
  assign fire    = retire && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (arm)                cnt <= CW'(SLOTS);
    else if (retire && pending)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/ccs_engine.sv
module ccs_engine
  import ccs_pkg::*;
#(
  parameter int SH_DEPTH  = 16,
  parameter int AUX_DEPTH = 8,
  parameter int DLY_SLOTS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_valid,
  input  logic [2:0]  instr_op,
  input  logic [1:0]  stk_sel,
  input  logic [15:0] tgt_val,
  input  logic        tgt_rel,
  input  logic        tgl_mode,
  input  logic        dly_br,
  input  logic        wr_z,
  input  logic        wr_c,
  input  logic        z_in,
  input  logic        c_in,
  input  logic        sh_gnt,
  output logic [15:0] pc,
  output logic        exec_mode,
  output logic        flag_z,
  output logic        flag_c,
  output logic        busy
);
  localparam int SH_AW  = $clog2(SH_DEPTH);
  localparam int AUX_AW = $clog2(AUX_DEPTH);
  localparam int PTR_W  = 16;

  st_e    state, state_nx;
  instr_t op_q, in_i, cur_i;
  logic   dly_pend, dly_fire, st_wait;

  always_comb begin
    in_i.sel = stk_sel;
    in_i.tgt = tgt_val;
    in_i.rel = tgt_rel;
    in_i.tgl = tgl_mode;
    in_i.dly = dly_br;
    in_i.wz  = wr_z;
    in_i.wc  = wr_c;
    case (instr_op)
      3'd1:    in_i.op = OP_SETF;
      3'd2:    in_i.op = OP_JMP;
      3'd3:    in_i.op = OP_CALL;
      3'd4:    in_i.op = OP_RET;
      default: in_i.op = OP_NOP;
    endcase
    // branches inside a delay window act as plain instructions
    if (dly_pend && (in_i.op == OP_JMP || in_i.op == OP_CALL || in_i.op == OP_RET))
      in_i.op = OP_NOP;
  end

  logic accept;
  assign accept  = (state == ST_IDLE) && instr_valid;
  assign cur_i   = (state == ST_IDLE) ? in_i : op_q;
  assign busy    = (state != ST_IDLE);
  assign st_wait = (state == ST_GNT);

  logic is_aux;
  assign is_aux = cur_i.sel[1];

  logic plain_go, jmp_go, call_aux, call_sh, call_go, rd_aux, rd_sh, ret_go;
  assign plain_go = accept && (in_i.op == OP_NOP || in_i.op == OP_SETF);
  assign jmp_go   = accept && in_i.op == OP_JMP;
  assign call_aux = accept && in_i.op == OP_CALL && is_aux;
  assign call_sh  = st_wait && sh_gnt && op_q.op == OP_CALL;
  assign call_go  = call_aux || call_sh;
  assign rd_aux   = accept && in_i.op == OP_RET && is_aux;
  assign rd_sh    = st_wait && sh_gnt && op_q.op == OP_RET;
  assign ret_go   = (state == ST_RD);

  logic [PTR_W-1:0] ptr_cur, ptr_prev;
  ccs_ptr_file #(.SH_DEPTH(SH_DEPTH), .AUX_DEPTH(AUX_DEPTH), .PW(PTR_W)) u_ptrs (
    .clk(clk), .rst(rst), .sel(cur_i.sel), .inc(call_go), .dec(rd_aux || rd_sh),
    .cur(ptr_cur), .prev(ptr_prev)
  );

  logic [PC_W-1:0]   tgt_eff, ret_addr;
  logic [WORD_W-1:0] frame, sh_rd, aux_rd, rd_word;
  assign tgt_eff  = cur_i.rel ? (pc + cur_i.tgt) : cur_i.tgt;
  assign ret_addr = pc + (cur_i.dly ? PC_W'(DLY_SLOTS + 1) : PC_W'(1));
  assign frame    = pack_frame(exec_mode, flag_z, flag_c, ret_addr);

  ccs_stack_mem #(.DEPTH(SH_DEPTH), .DW(WORD_W)) u_sh_mem (
    .clk(clk), .we(call_sh), .waddr(ptr_cur[SH_AW-1:0]), .wdata(frame),
    .re(rd_sh), .raddr(ptr_prev[SH_AW-1:0]), .rdata(sh_rd)
  );
  ccs_stack_mem #(.DEPTH(AUX_DEPTH), .DW(WORD_W)) u_aux_mem (
    .clk(clk), .we(call_aux), .waddr(ptr_cur[AUX_AW-1:0]), .wdata(frame),
    .re(rd_aux), .raddr(ptr_prev[AUX_AW-1:0]), .rdata(aux_rd)
  );

  assign rd_word = op_q.sel[1] ? aux_rd : sh_rd;

  logic unused_bits;
  assign unused_bits = ^{rd_word[WORD_W-1:MODE_BIT+1], ptr_cur[PTR_W-1:AUX_AW],
                         ptr_prev[PTR_W-1:AUX_AW]};

  logic            br_go, br_mode, br_zen, br_cen;
  logic [PC_W-1:0] br_pc;
  assign br_go   = jmp_go || call_go || ret_go;
  assign br_pc   = ret_go ? rd_word[PC_W-1:0] : tgt_eff;
  assign br_mode = ret_go ? rd_word[MODE_BIT] : (exec_mode ^ cur_i.tgl);
  assign br_zen  = ret_go && cur_i.wz;
  assign br_cen  = ret_go && cur_i.wc;

  ccs_delay #(.SLOTS(DLY_SLOTS)) u_dly (
    .clk(clk), .rst(rst), .arm(br_go && cur_i.dly), .retire(plain_go),
    .pending(dly_pend), .fire(dly_fire)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept && (in_i.op == OP_CALL || in_i.op == OP_RET)) begin
        if (!in_i.sel[1])           state_nx = ST_GNT;
        else if (in_i.op == OP_RET) state_nx = ST_RD;
      end
      ST_GNT:  if (sh_gnt) state_nx = (op_q.op == OP_RET) ? ST_RD : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  logic [PC_W-1:0] pend_pc;
  logic            pend_mode, pend_zen, pend_z, pend_cen, pend_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= '0;
      pc        <= '0;
      exec_mode <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      pend_pc   <= '0;
      pend_mode <= 1'b0;
      pend_zen  <= 1'b0;
      pend_z    <= 1'b0;
      pend_cen  <= 1'b0;
      pend_c    <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) op_q <= in_i;
      if (br_go) begin
        if (!cur_i.dly) begin
          pc        <= br_pc;
          exec_mode <= br_mode;
          if (br_zen) flag_z <= rd_word[ZF_BIT];
          if (br_cen) flag_c <= rd_word[CF_BIT];
        end else begin
          pc        <= pc + PC_W'(1);
          pend_pc   <= br_pc;
          pend_mode <= br_mode;
          pend_zen  <= br_zen;
          pend_z    <= rd_word[ZF_BIT];
          pend_cen  <= br_cen;
          pend_c    <= rd_word[CF_BIT];
        end
      end else if (plain_go) begin
        if (in_i.op == OP_SETF) begin
          flag_z <= z_in;
          flag_c <= c_in;
        end
        if (dly_fire) begin
          pc        <= pend_pc;
          exec_mode <= pend_mode;
          if (pend_zen) flag_z <= pend_z;
          if (pend_cen) flag_c <= pend_c;
        end else begin
          pc <= pc + PC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ccs_engine_chk.sv
module ccs_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [2:0]  instr_op,
  input logic [1:0]  stk_sel,
  input logic [15:0] tgt_val,
  input logic        tgt_rel,
  input logic        tgl_mode,
  input logic        dly_br,
  input logic        wr_z,
  input logic        sh_gnt,
  input logic [15:0] pc,
  input logic        exec_mode,
  input logic        flag_z,
  input logic        busy,
  input logic        dly_pend,
  input logic        st_wait
);
  logic take;
  assign take = instr_valid && !busy && !dly_pend;

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wait && !sh_gnt) |=> (st_wait && busy && $stable(pc)));

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (take && instr_op == 3'd0) |=> (pc == $past(pc) + 16'd1));

  // R3
  jmp_abs_chk: assert property (@(posedge clk) disable iff (rst)
    (take && instr_op == 3'd2 && !tgt_rel && !dly_br) |=> (pc == $past(tgt_val)));

  // R4
  jmp_tgl_chk: assert property (@(posedge clk) disable iff (rst)
    (take && instr_op == 3'd2 && !dly_br && tgl_mode) |=> (exec_mode != $past(exec_mode)));

  // R5
  aux_call_chk: assert property (@(posedge clk) disable iff (rst)
    (take && instr_op == 3'd3 && stk_sel[1] && !tgt_rel && !dly_br)
      |=> (pc == $past(tgt_val) && !busy));

  // R7
  keep_z_chk: assert property (@(posedge clk) disable iff (rst)
    (take && instr_op == 3'd4 && stk_sel[1] && !wr_z) |=> $stable(flag_z) ##1 $stable(flag_z));

  // R10
  dly_first_chk: assert property (@(posedge clk) disable iff (rst)
    (take && instr_op == 3'd2 && dly_br) |=> (pc == $past(pc) + 16'd1 && dly_pend));
endmodule

bind ccs_engine ccs_engine_chk u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
  .stk_sel(stk_sel), .tgt_val(tgt_val), .tgt_rel(tgt_rel), .tgl_mode(tgl_mode),
  .dly_br(dly_br), .wr_z(wr_z), .sh_gnt(sh_gnt), .pc(pc), .exec_mode(exec_mode),
  .flag_z(flag_z), .busy(busy), .dly_pend(dly_pend), .st_wait(st_wait)
);

// File: tb/ccs_engine_tb.sv
`timescale 1ns/1ps
module ccs_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [2:0]  instr_op = 3'd0;
  logic [1:0]  stk_sel = 2'd0;
  logic [15:0] tgt_val = 16'd0;
  logic        tgt_rel = 1'b0, tgl_mode = 1'b0, dly_br = 1'b0;
  logic        wr_z = 1'b0, wr_c = 1'b0, z_in = 1'b0, c_in = 1'b0;
  logic        sh_gnt = 1'b1;
  logic [15:0] pc;
  logic        exec_mode, flag_z, flag_c, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ccs_engine u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .stk_sel(stk_sel), .tgt_val(tgt_val), .tgt_rel(tgt_rel), .tgl_mode(tgl_mode),
    .dly_br(dly_br), .wr_z(wr_z), .wr_c(wr_c), .z_in(z_in), .c_in(c_in),
    .sh_gnt(sh_gnt), .pc(pc), .exec_mode(exec_mode), .flag_z(flag_z),
    .flag_c(flag_c), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] op, input logic [1:0] sel, input logic [15:0] t,
                     input logic rel, input logic tgl, input logic dly,
                     input logic wz, input logic wc, input logic zi, input logic ci);
    instr_valid = 1'b1; instr_op = op; stk_sel = sel; tgt_val = t; tgt_rel = rel;
    tgl_mode = tgl; dly_br = dly; wr_z = wz; wr_c = wc; z_in = zi; c_in = ci;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic run(input logic [2:0] op, input logic [1:0] sel, input logic [15:0] t,
                     input logic rel, input logic tgl, input logic dly,
                     input logic wz, input logic wc, input logic zi, input logic ci);
    put(op, sel, t, rel, tgl, dly, wz, wc, zi, ci);
    while (busy) @(negedge clk);
  endtask

  task automatic nop();                       run(3'd0, 2'd0, 16'h0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic setf(input logic z, input logic c); run(3'd1, 2'd0, 16'h0, 0, 0, 0, 0, 0, z, c); endtask
  task automatic jmp(input logic [15:0] t, input logic rel, input logic tgl, input logic dly);
    run(3'd2, 2'd0, t, rel, tgl, dly, 0, 0, 0, 0);
  endtask
  task automatic call(input logic [1:0] s, input logic [15:0] t, input logic tgl, input logic dly);
    run(3'd3, s, t, 0, tgl, dly, 0, 0, 0, 0);
  endtask
  task automatic ret(input logic [1:0] s, input logic wz, input logic wc, input logic tgl, input logic dly);
    run(3'd4, s, 16'h0, 0, tgl, dly, wz, wc, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 0);
    chk("R1 mode", exec_mode, 0);
    chk("R1 flags", {flag_z, flag_c}, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_plain();
    nop();          chk("R2 plain step", pc, 16'h1);
    setf(1, 0);     chk("R2 setf pc", pc, 16'h2); chk("R2 setf flags", {flag_z, flag_c}, 2'b10);
    setf(0, 1);     chk("R2 setf flags b", {flag_z, flag_c}, 2'b01);
    run(3'd6, 2'd0, 16'h0, 0, 0, 0, 0, 0, 0, 0); chk("R2 spare opcode", pc, 16'h4);
  endtask

  task automatic t_jump();
    jmp(16'h0100, 0, 0, 0); chk("R3 abs", pc, 16'h0100);
    jmp(16'h0010, 1, 0, 0); chk("R3 rel fwd", pc, 16'h0110);
    jmp(16'hFFFE, 1, 0, 0); chk("R3 rel back", pc, 16'h010E);
    chk("R3 mode kept", exec_mode, 0);
  endtask

  task automatic t_toggle();
    jmp(16'h0200, 0, 1, 0); chk("R4 tgl on", {exec_mode, pc}, {1'b1, 16'h0200});
    jmp(16'h0210, 0, 1, 0); chk("R4 tgl off", exec_mode, 0);
    jmp(16'h0220, 0, 0, 0); chk("R4 no tgl", exec_mode, 0);
  endtask

  task automatic t_call_aux();
    setf(1, 1);                 // pc 0x221
    jmp(16'h0300, 0, 1, 0);     // mode 1
    call(2'd2, 16'h0400, 1, 0);
    chk("R5 call pc", pc, 16'h0400); chk("R4 call tgl", exec_mode, 0);
    setf(0, 0);
    ret(2'd2, 1, 0, 1, 0);
    chk("R6 ret pc", pc, 16'h0301); chk("R6 R4 ret mode", exec_mode, 1);
    chk("R7 z restored", flag_z, 1); chk("R7 c kept", flag_c, 0);
    call(2'd2, 16'h0500, 0, 0); // saves z1 c0
    setf(0, 1);
    ret(2'd2, 0, 1, 0, 0);
    chk("R7 only c", {pc, flag_z, flag_c}, {16'h0302, 1'b0, 1'b0});
  endtask

  task automatic t_shared();
    setf(1, 0);                 // pc 0x303
    sh_gnt = 1'b0;
    put(3'd3, 2'd0, 16'h0600, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 busy on wait", busy, 1);
    put(3'd2, 2'd0, 16'h0777, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 pc held", pc, 16'h0303); chk("R9 still busy", busy, 1);
    sh_gnt = 1'b1;
    @(negedge clk);
    chk("R9 call done", {busy, pc}, {1'b0, 16'h0600});
    setf(0, 1);                 // pc 0x601
    sh_gnt = 1'b0;
    put(3'd4, 2'd0, 16'h0, 0, 0, 0, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R9 ret held", {busy, pc}, {1'b1, 16'h0601});
    sh_gnt = 1'b1;
    while (busy) @(negedge clk);
    chk("R5 R6 shared frame", {exec_mode, flag_z, flag_c, pc}, {1'b1, 1'b1, 1'b0, 16'h0304});
  endtask

  task automatic t_indep();
    jmp(16'h1000, 0, 0, 0);
    call(2'd0, 16'h1100, 0, 0);
    call(2'd1, 16'h1200, 0, 0);
    call(2'd2, 16'h1300, 0, 0);
    call(2'd3, 16'h1400, 0, 0);
    ret(2'd0, 0, 0, 0, 0); chk("R8 stack A", pc, 16'h1001);
    ret(2'd3, 0, 0, 0, 0); chk("R8 stack Y", pc, 16'h1301);
    ret(2'd1, 0, 0, 0, 0); chk("R8 stack B", pc, 16'h1101);
    ret(2'd2, 0, 0, 0, 0); chk("R8 stack X", pc, 16'h1201);
  endtask

  task automatic t_delay();
    jmp(16'h2000, 0, 0, 1); chk("R10 slot0", pc, 16'h1202);
    nop();                  chk("R10 slot1", pc, 16'h1203);
    nop();                  chk("R10 slot2", pc, 16'h1204);
    nop();                  chk("R10 taken", pc, 16'h2000);
    call(2'd2, 16'h2100, 0, 1); nop(); nop();
    chk("R10 call slot", pc, 16'h2003);
    nop();                  chk("R10 call taken", pc, 16'h2100);
    ret(2'd2, 0, 0, 0, 0);  chk("R5 delayed ret addr", pc, 16'h2004);
    call(2'd2, 16'h2200, 0, 0);
    ret(2'd2, 0, 0, 0, 1);  chk("R10 ret slot0", pc, 16'h2201);
    nop(); nop(); nop();    chk("R10 ret taken", pc, 16'h2005);
  endtask

  task automatic t_slot();
    jmp(16'h3000, 0, 0, 1);
    jmp(16'h3500, 0, 0, 0);     chk("R11 jmp in slot", pc, 16'h2007);
    call(2'd2, 16'h3600, 0, 0); chk("R11 call in slot", pc, 16'h2008);
    nop();                      chk("R11 outer taken", pc, 16'h3000);
  endtask

  task automatic t_wrap();
    logic [15:0] ra [9];
    for (int k = 0; k < 9; k++) begin
      ra[k] = pc + 16'd1;
      call(2'd3, 16'h4000 + 16'(k * 16), 0, 0);
    end
    ret(2'd3, 0, 0, 0, 0); chk("R12 newest", pc, ra[8]);
    for (int k = 0; k < 7; k++) ret(2'd3, 0, 0, 0, 0);
    chk("R12 second", pc, ra[1]);
    ret(2'd3, 0, 0, 0, 0); chk("R12 wrapped slot", pc, ra[8]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_jump();
    t_toggle();
    t_call_aux();
    t_shared();
    t_indep();
    t_delay();
    t_slot();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule